// File: doc/BRIEF.md
# Diode-Emulation Mode Selector

This block chooses, once per switching cycle, whether a synchronous buck converter runs with continuous conduction (CCM) or with diode emulation (DEM). Each low-side gate turn-on is reported by a one-cycle pulse strobe. On the clock cycle after each strobe, the block reads a digitised sign bit of the phase-node voltage and uses it to track a run of positive readings.

A long enough unbroken run of positive readings moves the converter into DEM. A single negative reading sends it back to CCM. A negative reading means the low-side body diode is carrying positive inductor current. A new mode takes effect only at the next strobe, so the mode never changes partway through a switching cycle. While in DEM the block also asks the modulator to scale its ripple window. That request is held off whenever the audio filter is enabled.

Top module: `dms_mode_select`

## Requirements
- R1: After reset, `dem_mode` and `win_scale_req` are 0 (CCM), and the positive-run count is zero.
- R2: After RUN_LEN (default 8) consecutive positive samples (`phase_pos`=1), the next rising edge on which `pulse_stb`=1 sets `dem_mode` to 1.
- R3: A negative sample clears the run count. Seven positives, then one negative, then seven more positives leave `dem_mode` at 0.
- R4: When a negative sample (`phase_pos`=0) is taken while in DEM, `dem_mode` returns to 0 on the next edge where `pulse_stb`=1.
- R5: `phase_pos` is sampled only on the clock cycle after a `pulse_stb` cycle. Its value on any other cycle has no effect.
- R6: `dem_mode` changes only on a clock edge at which `pulse_stb` is 1.
- R7: `win_scale_req` equals `dem_mode` AND NOT `audio_en`. Enabling the audio filter suppresses the request.
- R8: The run count saturates at RUN_LEN and does not wrap. After 30 consecutive positive samples the block stays in DEM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_stb | input | 1 | One-cycle strobe at each low-side gate turn-on |
| phase_pos | input | 1 | Phase-node sign, 1 = positive (read the cycle after the strobe) |
| audio_en | input | 1 | Audio filter enabled; blocks the window request |
| dem_mode | output | 1 | 1 = diode emulation, 0 = continuous conduction |
| win_scale_req | output | 1 | Request to scale the ripple window |

## Verification
Long random runs bias `phase_pos` towards positive, so the block crosses into DEM and drops out of it many times. These runs are mixed with back-to-back strobes, which separate the count that is loaded from the count that is being updated. Directed runs of seven positives followed by a break, and of thirty positives, show the difference between a count that clears or saturates and one that is off by one or wraps. Toggling `phase_pos` on cycles that are not sampled shows whether the sampling window is obeyed. Toggling `audio_en` while in DEM separates the window request from the mode itself.

// File: rtl/dms_pkg.sv
package dms_pkg;
   typedef enum logic {
      MODE_CCM = 1'b0,
      MODE_DEM = 1'b1
   } conv_mode_t;
endpackage

// File: rtl/dms_sample_stage.sv
module dms_sample_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_stb,
   input  logic phase_pos,
   output logic smp_valid,
   output logic smp_pos
);
   logic stb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= pulse_stb;
   end

   assign smp_valid = stb_q;
   assign smp_pos   = phase_pos;
endmodule

// File: rtl/dms_run_counter.sv
module dms_run_counter #(
   parameter int RUN_LEN = 8,
   localparam int CW = $clog2(RUN_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic smp_pos,
   output logic run_full
);
   localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (smp_valid) begin
         if (!smp_pos)            run_q <= '0;
         else if (run_q != LIMIT) run_q <= run_q + 1'b1;
      end
   end

   assign run_full = (run_q == LIMIT);
endmodule

// File: rtl/dms_mode_reg.sv
module dms_mode_reg
   import dms_pkg::*;
#(
   parameter bit WIN_REGISTERED = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pulse_stb,
   input  logic       run_full,
   input  logic       audio_en,
   output conv_mode_t mode,
   output logic       win_req
);
   conv_mode_t mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         mode_q <= MODE_CCM;
      else if (pulse_stb) mode_q <= run_full ? MODE_DEM : MODE_CCM;
   end

   assign mode = mode_q;

   generate
      if (WIN_REGISTERED) begin : g_win_reg
         logic win_q;
         always_ff @(posedge clk) begin
            if (!rst_n) win_q <= 1'b0;
            else        win_q <= (mode_q == MODE_DEM) && !audio_en;
         end
         assign win_req = win_q;
      end else begin : g_win_comb
         assign win_req = (mode_q == MODE_DEM) && !audio_en;
      end
   endgenerate
endmodule

// File: rtl/dms_mode_select.sv
module dms_mode_select
   import dms_pkg::*;
#(
   parameter int RUN_LEN        = 8,
   parameter bit WIN_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_stb,
   input  logic phase_pos,
   input  logic audio_en,
   output logic dem_mode,
   output logic win_scale_req
);
   generate
      if (RUN_LEN < 1 || RUN_LEN > 255) begin : g_bad_len
         $error("dms_mode_select: RUN_LEN out of range");
      end
   endgenerate

   logic       smp_valid, smp_pos, run_full;
   conv_mode_t mode;

   dms_sample_stage u_smp (
      .clk(clk), .rst_n(rst_n), .pulse_stb(pulse_stb), .phase_pos(phase_pos),
      .smp_valid(smp_valid), .smp_pos(smp_pos)
   );

   dms_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_pos(smp_pos),
      .run_full(run_full)
   );

   dms_mode_reg #(.WIN_REGISTERED(WIN_REGISTERED)) u_mode (
      .clk(clk), .rst_n(rst_n), .pulse_stb(pulse_stb), .run_full(run_full),
      .audio_en(audio_en), .mode(mode), .win_req(win_scale_req)
   );

   assign dem_mode = (mode == MODE_DEM);
endmodule

// File: rtl/dms_mode_select_chk.sv
module dms_mode_select_chk (
   input logic clk,
   input logic rst_n,
   input logic pulse_stb,
   input logic phase_pos,
   input logic audio_en,
   input logic dem_mode,
   input logic win_scale_req
);
   logic stb_seen, neg_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_seen <= 1'b0;
         neg_pend <= 1'b0;
      end else begin
         stb_seen <= pulse_stb;
         if (stb_seen && !phase_pos) neg_pend <= 1'b1;
         else if (pulse_stb)         neg_pend <= 1'b0;
      end
   end

   // R1: CCM on leaving reset
   p_reset_ccm_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dem_mode && !win_scale_req);

   // R6: the mode moves only at a strobe edge
   p_mode_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_stb |=> $stable(dem_mode));

   // R4: a pending negative sample forces CCM at the next strobe
   p_neg_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_stb && neg_pend) |=> !dem_mode);

   // R7: audio filter blocks the window request
   p_audio_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      audio_en |-> !win_scale_req);

   // R7: without audio filtering the request follows DEM
   p_win_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!audio_en) |-> (win_scale_req == dem_mode));
endmodule

bind dms_mode_select dms_mode_select_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pulse_stb(pulse_stb), .phase_pos(phase_pos),
   .audio_en(audio_en), .dem_mode(dem_mode), .win_scale_req(win_scale_req)
);

// File: tb/dms_mode_select_test.sv
module dms_mode_select_test;
   localparam int CLK_PERIOD = 10;
   localparam int RUN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse_stb = 1'b0, phase_pos = 1'b0, audio_en = 1'b0;
   logic dem_mode, win_scale_req;

   int n_chk = 0, n_bad = 0;
   int m_cnt = 0;
   bit m_stbd = 0, m_mode = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dms_mode_select #(.RUN_LEN(RUN)) uut (
      .clk(clk), .rst_n(rst_n), .pulse_stb(pulse_stb), .phase_pos(phase_pos),
      .audio_en(audio_en), .dem_mode(dem_mode), .win_scale_req(win_scale_req)
   );

   function automatic bit exp_win(bit mode, bit aud);
      return mode && !aud;
   endfunction

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // drive at negedge, advance one edge, update the model, check at next negedge
   task automatic step(bit stb, bit ph, bit aud);
      int old_cnt;
      pulse_stb = stb; phase_pos = ph; audio_en = aud;
      @(posedge clk);
      old_cnt = m_cnt;
      if (m_stbd) m_cnt = ph ? ((m_cnt < RUN) ? m_cnt + 1 : m_cnt) : 0;
      if (stb) m_mode = (old_cnt == RUN);
      m_stbd = stb;
      @(negedge clk);
      check("R2", dem_mode, m_mode);
      check("R7", win_scale_req, exp_win(m_mode, aud));
   endtask

   // one switching cycle: strobe, sample, one idle with the sign inverted
   task automatic cyc(bit ph);
      step(1, ~ph, 0);
      step(0, ph, 0);
      step(0, ~ph, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", dem_mode, 1'b0);
      check("R1", win_scale_req, 1'b0);
      rst_n = 1'b1;
      step(0, 0, 0);
      check("R1", dem_mode, 1'b0);

      // R3: seven positives, one negative, seven positives -> still CCM
      for (int i = 0; i < 7; i++) cyc(1);
      cyc(0);
      for (int i = 0; i < 7; i++) cyc(1);
      step(1, 0, 0);
      check("R3", dem_mode, 1'b0);
      step(0, 1, 0); step(0, 0, 0);
      // eighth positive now completes the run; R2 at next strobe
      step(1, 0, 0);
      check("R2", dem_mode, 1'b1);
      step(0, 1, 0);

      // R8: long positive run, stays in DEM
      for (int i = 0; i < 30; i++) cyc(1);
      step(1, 0, 0);
      check("R8", dem_mode, 1'b1);
      step(0, 1, 0);

      // R5: inverted sign on unsampled cycles already applied by cyc; verify idle toggles
      for (int i = 0; i < 6; i++) step(0, i[0], 0);
      step(1, 0, 0);
      check("R5", dem_mode, 1'b1);

      // R7: audio suppresses request while in DEM
      step(0, 1, 1);
      check("R7", win_scale_req, 1'b0);
      step(0, 0, 0);
      check("R7", win_scale_req, 1'b1);

      // R4 and R6: negative sample exits only at next strobe
      step(1, 1, 0);
      step(0, 0, 0);
      step(0, 1, 0);
      check("R6", dem_mode, 1'b1);
      step(1, 1, 0);
      check("R4", dem_mode, 1'b0);
      step(0, 1, 0);

      // random: biased positive phase, mixed strobe spacing and audio
      for (int i = 0; i < 20000; i++) begin
         bit s, p, a;
         s = ($urandom % 3) == 0;
         p = ($urandom % 16) != 0;
         a = ($urandom % 8) == 0;
         step(s, p, a);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule